// File: doc/BRIEF.md
# Sector Page-Load Program Controller

This controller sits between an asynchronous byte-wide parallel bus and the write port of a non-volatile array. It samples the chip-enable, output-enable and write-enable strobes, the address and the data in the system clock domain. Write pulses are filtered and turned into byte loads that fill a one-sector page buffer. Once the bus has been quiet for a programmable window after the last load, the controller runs a self-timed cycle on its own. That cycle erases the whole sector to all-ones, programs the loaded bytes and then holds busy until the cycle time has elapsed.

While the cycle runs, a read returns a status byte instead of array data. The top bit is the inverse of the top bit of the last loaded byte. The next bit flips with every new read. The low bits repeat the last loaded byte. When idle, a read returns the array word at the sampled address. All timing limits are parameters in clock ticks, so the same block serves real-time settings and short simulations.

Top module: `sector_pgm_ctrl`

## Requirements
- R1: After reset, busy, dq_oe and mem_we are all 0.
- R2: A write-enable low pulse with chip-enable low and output-enable high loads one byte. The address is taken as the strobe becomes active and the data as it ends. After the cycle, each loaded byte reads back unchanged.
- R3: The cycle erases every byte of the sector first. Bytes not loaded in the page, loaded in any order, read back as 0xFF afterwards, even when they held other data before.
- R4: The load window stays open while each new load starts within WIN_TICKS of the end of the previous accepted one. Busy rises about WIN_TICKS cycles after the end of the last load, and not before.
- R5: The sector is address bits [16:7] and the byte index is bits [6:0]. A load whose sector differs from the first load of the page is dropped. No array write ever leaves the page's sector.
- R6: A write pulse while output-enable is low, or while chip-enable is high, loads nothing and starts no cycle.
- R7: A write pulse shorter than FILT_TICKS sampled cycles loads nothing.
- R8: While busy, bit 7 of a read is the inverse of bit 7 of the last loaded byte, and bits [5:0] equal its bits [5:0].
- R9: While busy, bit 6 is 0 at the start of the cycle and flips once at the start of each read, so the first read shows 1. It does not change otherwise and stops when busy ends.
- R10: Loads that arrive while busy are ignored. They do not change the status byte, do not reach the array and start no new cycle.
- R11: Busy stays high for exactly CYC_TICKS clock cycles. Array writes occur only while busy.
- R12: dq_oe is 1 only while a read is sampled (chip-enable low, output-enable low, write-enable high). An idle read returns the array word at the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | AW | Bus address |
| din | input | DW | Bus write data |
| mem_rdata | input | DW | Array read data, one cycle after mem_raddr |
| dout | output | DW | Read data or busy status |
| dq_oe | output | 1 | Drive enable for dout; low means high impedance |
| busy | output | 1 | Self-timed cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | DW | Array write data |
| mem_raddr | output | AW | Array read address |

## Verification
Read data follows the strobes after two synchronizer stages and the one-cycle array read. The toggle bit moves one cycle later still, so every read holds its strobes six cycles before the monitor samples dout at a falling clock edge. A byte load is committed about FILT_TICKS plus three cycles after write-enable falls. Busy is therefore checked in a bracket: still low about 110 cycles after the last release and high at 260, against a 200-tick window. Busy length is measured on falling edges and compared with CYC_TICKS exactly, and the array is read back through the ports only after busy has fallen.

// File: rtl/spc_pkg.sv
package spc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_ERASE,
      ST_PROG,
      ST_WAIT
   } spc_state_e;
endpackage

// File: rtl/spc_strobe_in.sv
// Synchronizes bus strobes and buses, filters write pulses, produces
// load start/end pulses with captured address and data.
module spc_strobe_in #(
   parameter int AW   = 17,
   parameter int DW   = 8,
   parameter int SYNC = 2,
   parameter int FILT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   output logic          rd_act,
   output logic [AW-1:0] rd_addr,
   output logic          wr_filt,
   output logic          load_go,
   output logic          load_done,
   output logic [AW-1:0] cap_addr,
   output logic [DW-1:0] cap_data
);
   localparam int W  = 3 + AW + DW;
   localparam int CW = $clog2(FILT + 1);
   localparam logic [W-1:0] RST_V = {3'b111, {(AW + DW){1'b0}}};
   localparam logic [CW-1:0] CNT_TOP = CW'(FILT - 1);

   logic [SYNC-1:0][W-1:0] stg;
   logic                   ce_s, oe_s, we_s;
   logic [AW-1:0]          a_s;
   logic [DW-1:0]          d_s;
   logic                   wr_raw;
   logic [CW-1:0]          cnt;
   logic                   set_now;

   for (genvar g = 0; g < SYNC; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_V;
            else        stg[0] <= {ce_n, oe_n, we_n, addr, din};
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_V;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   assign {ce_s, oe_s, we_s, a_s, d_s} = stg[SYNC-1];
   assign wr_raw  = !ce_s && !we_s && oe_s;
   assign rd_act  = !ce_s && !oe_s && we_s;
   assign rd_addr = a_s;
   assign set_now = wr_raw && !wr_filt && (cnt == CNT_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         wr_filt   <= 1'b0;
         load_go   <= 1'b0;
         load_done <= 1'b0;
         cap_addr  <= '0;
         cap_data  <= '0;
      end else begin
         load_go   <= set_now;
         load_done <= !wr_raw && wr_filt;
         if (set_now) cap_addr <= a_s;
         if (!wr_raw && wr_filt) cap_data <= d_s;
         if (!wr_raw) begin
            cnt     <= '0;
            wr_filt <= 1'b0;
         end else if (!wr_filt) begin
            if (cnt == CNT_TOP) wr_filt <= 1'b1;
            else                cnt     <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spc_page_buf.sv
// One-sector page buffer with a per-byte loaded mask.
module spc_page_buf #(
   parameter int DW = 8,
   parameter int PB = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [PB-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [PB-1:0] rd_idx,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid
);
   localparam int PAGE = 1 << PB;

   logic [DW-1:0]   store [PAGE];
   logic [PAGE-1:0] valid;

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_idx] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     valid <= '0;
      else if (clr)   valid <= '0;
      else if (wr_en) valid[wr_idx] <= 1'b1;
   end

   assign rd_data  = store[rd_idx];
   assign rd_valid = valid[rd_idx];
endmodule

// File: rtl/spc_seq.sv
// Load window, self-timed erase/program sequencing and busy status.
module spc_seq
   import spc_pkg::*;
#(
   parameter int AW         = 17,
   parameter int DW         = 8,
   parameter int PB         = 7,
   parameter int WIN        = 37500,
   parameter int CYC        = 2500000,
   parameter bit ERASE_PASS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_go,
   input  logic          load_done,
   input  logic [AW-1:0] cap_addr,
   input  logic [DW-1:0] cap_data,
   input  logic          rd_act,
   input  logic [DW-1:0] buf_rdata,
   input  logic          buf_rvalid,
   output logic          buf_we,
   output logic [PB-1:0] buf_widx,
   output logic [DW-1:0] buf_wdata,
   output logic [PB-1:0] buf_ridx,
   output logic          buf_clr,
   output logic          busy,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic [DW-1:0] status
);
   localparam int SW  = AW - PB;
   localparam int WW  = $clog2(WIN + 1);
   localparam int YW  = $clog2(CYC + 1);
   localparam logic [DW-1:0] ERASED  = '1;
   localparam logic [WW-1:0] WIN_TOP = WW'(WIN - 1);
   localparam logic [YW-1:0] CYC_TOP = YW'(CYC - 1);

   spc_state_e    st;
   logic [SW-1:0] sec_q;
   logic [PB-1:0] idx;
   logic [WW-1:0] win;
   logic [YW-1:0] cyc;
   logic          in_stb, tog, rd_q, last_hi;
   logic [DW-3:0] last_lo;
   logic          accept, last_idx;

   assign accept   = (st == ST_IDLE) ||
                     ((st == ST_LOAD) && (cap_addr[AW-1:PB] == sec_q));
   assign buf_we   = load_done && accept;
   assign buf_widx = cap_addr[PB-1:0];
   assign buf_wdata = cap_data;
   assign buf_ridx = idx;
   assign busy     = (st == ST_ERASE) || (st == ST_PROG) || (st == ST_WAIT);
   assign buf_clr  = (st == ST_WAIT) && (cyc == CYC_TOP);
   assign mem_addr = {sec_q, idx};
   assign last_idx = (idx == '1);
   assign status   = {~last_hi, tog, last_lo};

   if (ERASE_PASS) begin : g_two_pass
      assign mem_we    = (st == ST_ERASE) || ((st == ST_PROG) && buf_rvalid);
      assign mem_wdata = (st == ST_PROG) ? buf_rdata : ERASED;
   end else begin : g_one_pass
      assign mem_we    = (st == ST_PROG);
      assign mem_wdata = buf_rvalid ? buf_rdata : ERASED;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         sec_q   <= '0;
         idx     <= '0;
         win     <= '0;
         cyc     <= '0;
         in_stb  <= 1'b0;
         tog     <= 1'b0;
         rd_q    <= 1'b0;
         last_hi <= 1'b0;
         last_lo <= '0;
      end else begin
         rd_q <= rd_act;
         if (busy && rd_act && !rd_q) tog <= ~tog;
         if (load_go)        in_stb <= 1'b1;
         else if (load_done) in_stb <= 1'b0;
         if (buf_we) begin
            last_hi <= cap_data[DW-1];
            last_lo <= cap_data[DW-3:0];
         end
         unique case (st)
            ST_IDLE: begin
               if (buf_we) begin
                  st    <= ST_LOAD;
                  sec_q <= cap_addr[AW-1:PB];
                  win   <= '0;
               end
            end
            ST_LOAD: begin
               if (buf_we) begin
                  win <= '0;
               end else if (!in_stb) begin
                  if (win == WIN_TOP) begin
                     st  <= ERASE_PASS ? ST_ERASE : ST_PROG;
                     idx <= '0;
                     cyc <= '0;
                     tog <= 1'b0;
                  end else begin
                     win <= win + 1'b1;
                  end
               end
            end
            ST_ERASE: begin
               cyc <= cyc + 1'b1;
               idx <= idx + 1'b1;
               if (last_idx) st <= ST_PROG;
            end
            ST_PROG: begin
               cyc <= cyc + 1'b1;
               idx <= idx + 1'b1;
               if (last_idx) st <= ST_WAIT;
            end
            ST_WAIT: begin
               if (cyc == CYC_TOP) st  <= ST_IDLE;
               else                cyc <= cyc + 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sector_pgm_ctrl.sv
module sector_pgm_ctrl #(
   parameter int AW         = 17,
   parameter int DW         = 8,
   parameter int PB         = 7,
   parameter int SYNC       = 2,
   parameter int FILT_TICKS = 4,
   parameter int WIN_TICKS  = 37500,
   parameter int CYC_TICKS  = 2500000,
   parameter bit ERASE_PASS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] dout,
   output logic          dq_oe,
   output logic          busy,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic [AW-1:0] mem_raddr
);
   localparam int PAGE = 1 << PB;

   if (SYNC < 2)              begin : g_bad_sync  $error("SYNC must be at least 2"); end
   if (FILT_TICKS < 1)        begin : g_bad_filt  $error("FILT_TICKS must be at least 1"); end
   if (WIN_TICKS < 2)         begin : g_bad_win   $error("WIN_TICKS must be at least 2"); end
   if (CYC_TICKS <= 2 * PAGE) begin : g_bad_cyc   $error("CYC_TICKS must exceed two page passes"); end
   if (DW < 3)                begin : g_bad_dw    $error("DW must be at least 3"); end
   if (PB >= AW)              begin : g_bad_pb    $error("PB must be below AW"); end

   logic          rd_act, wr_filt, load_go, load_done;
   logic [AW-1:0] cap_addr;
   logic [DW-1:0] cap_data, buf_rdata, buf_wdata, status;
   logic          buf_rvalid, buf_we, buf_clr;
   logic [PB-1:0] buf_widx, buf_ridx;

   spc_strobe_in #(.AW(AW), .DW(DW), .SYNC(SYNC), .FILT(FILT_TICKS)) u_in (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .rd_act(rd_act), .rd_addr(mem_raddr),
      .wr_filt(wr_filt), .load_go(load_go), .load_done(load_done),
      .cap_addr(cap_addr), .cap_data(cap_data)
   );

   spc_page_buf #(.DW(DW), .PB(PB)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_we),
      .wr_idx(buf_widx), .wr_data(buf_wdata), .rd_idx(buf_ridx),
      .rd_data(buf_rdata), .rd_valid(buf_rvalid)
   );

   spc_seq #(.AW(AW), .DW(DW), .PB(PB), .WIN(WIN_TICKS), .CYC(CYC_TICKS),
             .ERASE_PASS(ERASE_PASS)) u_seq (
      .clk(clk), .rst_n(rst_n), .load_go(load_go), .load_done(load_done),
      .cap_addr(cap_addr), .cap_data(cap_data), .rd_act(rd_act),
      .buf_rdata(buf_rdata), .buf_rvalid(buf_rvalid), .buf_we(buf_we),
      .buf_widx(buf_widx), .buf_wdata(buf_wdata), .buf_ridx(buf_ridx),
      .buf_clr(buf_clr), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .status(status)
   );

   assign dq_oe = rd_act;
   assign dout  = busy ? status : mem_rdata;
endmodule

// File: rtl/spc_chk.sv
module spc_chk #(
   parameter int AW  = 17,
   parameter int DW  = 8,
   parameter int PB  = 7,
   parameter int CYC = 2500000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             mem_we,
   input logic [AW-PB-1:0] mem_sec,
   input logic             dq_oe,
   input logic [DW-1:0]    dout
);
   int unsigned busy_cnt;
   logic        rd_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt <= 0;
         rd_d     <= 1'b0;
      end else begin
         busy_cnt <= busy ? busy_cnt + 1 : 0;
         rd_d     <= dq_oe;
      end
   end

   p_wr_in_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   p_busy_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_cnt == CYC));

   p_one_sector_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_sec == $past(mem_sec)));

   p_tog_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && dq_oe && !rd_d) |=> (!busy || (dout[DW-2] != $past(dout[DW-2]))));

   p_tog_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(dq_oe && !rd_d)) |-> $stable(dout[DW-2]));

   p_status_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(dout[DW-1]) && $stable(dout[DW-3:0])));
endmodule

bind sector_pgm_ctrl spc_chk #(.AW(AW), .DW(DW), .PB(PB), .CYC(CYC_TICKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .mem_we(mem_we),
   .mem_sec(mem_addr[AW-1:PB]), .dq_oe(dq_oe), .dout(dout)
);

// File: tb/sector_pgm_ctrl_test.sv
`timescale 1ns/1ps
module sector_pgm_ctrl_test;
   localparam int AW = 17, DW = 8, FILT = 3, WIN = 200, CYC = 600;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0, mem_rdata, dout, mem_wdata;
   logic          dq_oe, busy, mem_we;
   logic [AW-1:0] mem_addr, mem_raddr;

   int n_chk = 0, n_fail = 0;
   int run_len = 0, last_len = 0;

   typedef struct { logic [7:0] exp; string tag; } item_t;
   item_t sbq[$];
   event  mon_ev;

   logic [7:0] arr [512];

   always #2 clk = ~clk;

   sector_pgm_ctrl #(.FILT_TICKS(FILT), .WIN_TICKS(WIN), .CYC_TICKS(CYC)) uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .mem_rdata(mem_rdata), .dout(dout),
      .dq_oe(dq_oe), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_raddr(mem_raddr)
   );

   initial for (int i = 0; i < 512; i++) arr[i] = 8'(i) ^ 8'h3C;

   always @(posedge clk) begin
      if (mem_we) arr[mem_addr[8:0]] <= mem_wdata;
      mem_rdata <= arr[mem_raddr[8:0]];
   end

   always @(negedge clk) begin
      if (busy) run_len++;
      else if (run_len != 0) begin last_len = run_len; run_len = 0; end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read values and compares against the port
   initial forever begin
      item_t it;
      @(mon_ev);
      it = sbq.pop_front();
      chk(dq_oe === 1'b1, {it.tag, " drive"}, int'(dq_oe), 1);
      chk(dout === it.exp, it.tag, int'(dout), int'(it.exp));
   end

   task automatic cyc_wait(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic load(input logic [16:0] a, input logic [7:0] d,
                       input bit oe_low, input bit ce_high, input int width);
      @(negedge clk);
      addr = a; din = d; ce_n = ce_high; oe_n = !oe_low;
      cyc_wait(2);
      we_n = 1'b0;
      cyc_wait(width);
      we_n = 1'b1;
      cyc_wait(4);
      ce_n = 1'b1; oe_n = 1'b1;
      cyc_wait(6);
   endtask

   task automatic rd(input logic [16:0] a, input logic [7:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      addr = a; ce_n = 1'b0; oe_n = 1'b0;
      cyc_wait(6);
      it.exp = exp; it.tag = tag;
      sbq.push_back(it);
      -> mon_ev;
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
      cyc_wait(6);
   endtask

   task automatic wait_busy(input logic lvl, input int lim);
      for (int i = 0; i < lim && busy !== lvl; i++) @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      cyc_wait(4);
      // R1 reset state
      chk(busy === 1'b0, "R1 busy", int'(busy), 0);
      chk(dq_oe === 1'b0, "R1 dq_oe", int'(dq_oe), 0);
      chk(mem_we === 1'b0, "R1 mem_we", int'(mem_we), 0);
      rst_n = 1'b1;
      cyc_wait(4);

      // R12 idle read returns array word, and drive drops afterwards
      rd(17'h00005, 8'h39, "R12 idle read");
      chk(dq_oe === 1'b0, "R12 release", int'(dq_oe), 0);
      @(negedge clk); ce_n = 1'b0;
      cyc_wait(4);
      chk(dq_oe === 1'b0, "R12 ce only", int'(dq_oe), 0);
      ce_n = 1'b1;

      // R7 short pulse
      load(17'h00085, 8'h44, 1'b0, 1'b0, 2);
      cyc_wait(WIN + 50);
      chk(busy === 1'b0, "R7 glitch", int'(busy), 0);

      // R6 inhibits
      load(17'h00085, 8'h44, 1'b1, 1'b0, 8);
      load(17'h00086, 8'h45, 1'b0, 1'b1, 8);
      cyc_wait(WIN + 50);
      chk(busy === 1'b0, "R6 inhibit", int'(busy), 0);
      rd(17'h00085, 8'h85 ^ 8'h3C, "R6 array kept");

      // R2 R3 R4 R5: page in sector 1, out of order, one foreign load
      load(17'h00085, 8'h11, 1'b0, 1'b0, 8);
      load(17'h00080, 8'hC2, 1'b0, 1'b0, 8);
      load(17'h00103, 8'h55, 1'b0, 1'b0, 8);
      load(17'h000FF, 8'h7E, 1'b0, 1'b0, 8);
      load(17'h000C0, 8'h93, 1'b0, 1'b0, 8);
      cyc_wait(100);
      chk(busy === 1'b0, "R4 window open", int'(busy), 0);
      cyc_wait(150);
      chk(busy === 1'b1, "R4 window closed", int'(busy), 1);

      // R8 R9 R10 status while busy (last byte 0x93)
      rd(17'h000C0, 8'h53, "R8 R9 first poll");
      rd(17'h00001, 8'h13, "R9 second poll");
      load(17'h0008A, 8'h00, 1'b0, 1'b0, 8);
      rd(17'h000C0, 8'h53, "R10 poll after busy load");

      wait_busy(1'b0, CYC + 100);
      cyc_wait(2);
      chk(last_len == CYC, "R11 busy length", last_len, CYC);

      rd(17'h00085, 8'h11, "R2 byte 5");
      rd(17'h00080, 8'hC2, "R2 byte 0");
      rd(17'h000FF, 8'h7E, "R2 byte 127");
      rd(17'h000C0, 8'h93, "R2 byte 64");
      rd(17'h000C0, 8'h93, "R9 toggle stopped");
      rd(17'h00081, 8'hFF, "R3 unloaded byte");
      rd(17'h0008A, 8'hFF, "R10 busy load absent");
      rd(17'h00103, 8'h03 ^ 8'h3C, "R5 foreign sector kept");
      cyc_wait(WIN + 50);
      chk(busy === 1'b0, "R10 no extra cycle", int'(busy), 0);

      // R3 rewrite with one byte erases the rest; R8 with bit 7 clear
      load(17'h00080, 8'h2A, 1'b0, 1'b0, 8);
      wait_busy(1'b1, WIN + 100);
      rd(17'h00080, 8'hEA, "R8 poll bit7 low");
      wait_busy(1'b0, CYC + 100);
      cyc_wait(2);
      rd(17'h00080, 8'h2A, "R2 rewrite byte 0");
      rd(17'h00085, 8'hFF, "R3 old byte erased");

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule